// File: doc/BRIEF.md
# Bridge Interrupt Aggregator

This block collects a set of interrupt lines from the devices behind a bus bridge and turns them into one outbound memory-write transaction toward the processor. Each line is synchronized into the block's clock domain and watched for changes. A change on a line whose enable bit is set marks that line in two read-to-clear registers, the pending register and the request register. It also issues one write of a programmed data value to a programmed target address.

Software reaches the block through a simple strobe-based register port. The live-level register always shows the synchronized state of every line, whatever the enable bits hold. An interrupt service routine can use it after clearing the latched bits to find lines that are still asserted, and so emulate level-triggered behaviour on top of the change-triggered hardware. The target address and the data value come from one combined word: its low `DATA_FIELD_W` bits are the data value, and the remaining upper bits, with the low bits forced to zero, are the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable register, the pending register and the request register all read zero, and `msg_valid` is low.
- R2: The live-level register (select code 2) returns the input lines as they were two clock edges earlier. This holds for every line, whether its enable bit is set or not.
- R3: A change of either polarity on a line whose enable bit is set sets that line's bit in the pending register (select code 1) on the third clock edge after the input change. The same change also sets the bit in the request register.
- R4: A change on a line whose enable bit is clear sets no pending or request bit and issues no write. Setting the enable bit of a line that is already asserted raises nothing by itself.
- R5: A read of the pending register returns its bits and clears them in the same access. The live-level register and the request register are left unchanged by it.
- R6: A read of the request register (select code 3) returns only the implemented bits given by mask 0x5FF, so bit 9 always reads zero, and clears the request register in the same access.
- R7: On an enabled change the block raises `msg_valid`, carrying the combined word written to select code 4. `msg_data` is the low 8 bits of that word, zero-extended, and `msg_addr` is the word with those 8 bits cleared. Changes that fall on the same clock edge produce exactly one write.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R9: If enabled changes occur while a write is still waiting for `msg_ready`, exactly one further write follows once the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 11 | Asynchronous interrupt input lines |
| host_sel | input | 3 | Register select: 0 enable, 1 pending, 2 live level, 3 request, 4 target word |
| host_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, zero-extended |
| msg_valid | output | 1 | Outbound write request |
| msg_ready | input | 1 | Outbound write accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
A corrupted pending or request bit shows in the very next read of the matching register, and that read also clears it. Each vector in the bench therefore reads both registers after every stimulus step, so a stale bit cannot leak into the following step. A broken change detector or synchronizer shows three edges after an input change, either as a missing pending bit or as a write count that differs from one. A lost second-write flag shows only after a stall: one write is missing once `msg_ready` returns. For that reason the bench counts handshakes across a deliberate back-pressure window.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_LEVEL  = 3'd2,
        SEL_REQ    = 3'd3,
        SEL_TARGET = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } msg_t;

    // Split the combined target word into address and data halves.
    function automatic msg_t split_target(input logic [WORD_W-1:0] word, input int df_w);
        msg_t m;
        logic [WORD_W-1:0] low_mask;
        low_mask = (WORD_W'(1) << df_w) - WORD_W'(1);
        m.addr   = word & ~low_mask;
        m.data   = word & low_mask;
        return m;
    endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_async,
    output logic [N-1:0] level,
    output logic [N-1:0] change
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= lines_async;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign level  = stage2_q;
    assign change = stage2_q ^ prev_q;
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_agg_pkg::*;
#(
    parameter int           N            = 11,
    parameter logic [N-1:0] IMPL_MASK    = 11'h5FF,
    parameter int           DATA_FIELD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [N-1:0]      level,
    input  logic [N-1:0]      change,
    output logic [N-1:0]      enabled_change,
    output logic [N-1:0]      enable_q,
    output logic [N-1:0]      pend_q,
    output logic [N-1:0]      req_q,
    output msg_t              target
);
    localparam int PAD_W = WORD_W - N;

    logic [WORD_W-1:0] target_q;
    reg_sel_e          sel_e;
    logic              rd_pend;
    logic              rd_req;

    assign sel_e          = reg_sel_e'(sel);
    assign rd_pend        = rd && (sel_e == SEL_PEND);
    assign rd_req         = rd && (sel_e == SEL_REQ);
    assign enabled_change = change & enable_q;
    assign target         = split_target(target_q, DATA_FIELD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            pend_q   <= '0;
            req_q    <= '0;
            target_q <= '0;
        end else begin
            if (wr && sel_e == SEL_ENABLE) enable_q <= wdata[N-1:0];
            if (wr && sel_e == SEL_TARGET) target_q <= wdata;
            // a new event wins over a clearing read in the same cycle
            pend_q <= (rd_pend ? '0 : pend_q) | enabled_change;
            req_q  <= ((rd_req ? '0 : req_q) | enabled_change) & IMPL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel_e)
                SEL_ENABLE: rdata = {{PAD_W{1'b0}}, enable_q};
                SEL_PEND:   rdata = {{PAD_W{1'b0}}, pend_q};
                SEL_LEVEL:  rdata = {{PAD_W{1'b0}}, level};
                SEL_REQ:    rdata = {{PAD_W{1'b0}}, req_q & IMPL_MASK};
                SEL_TARGET: rdata = target_q;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_sender.sv
module irq_sender
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  msg_t target,
    output logic valid,
    input  logic ready,
    output msg_t msg
);
    logic valid_q;
    logic again_q;
    msg_t msg_q;
    logic launch;

    assign launch = (!valid_q && fire) || (valid_q && ready && (again_q || fire));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            again_q <= 1'b0;
            msg_q   <= '0;
        end else begin
            if (valid_q && ready) begin
                valid_q <= again_q || fire;
                again_q <= 1'b0;
            end else if (valid_q) begin
                again_q <= again_q || fire;
            end else begin
                valid_q <= fire;
            end
            if (launch) msg_q <= target;
        end
    end

    assign valid = valid_q;
    assign msg   = msg_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int           N            = 11,
    parameter logic [N-1:0] IMPL_MASK    = 11'h5FF,
    parameter int           DATA_FIELD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_lines,
    input  logic [2:0]        host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    logic [N-1:0] level;
    logic [N-1:0] change;
    logic [N-1:0] enabled_change;
    logic [N-1:0] enable_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] req_q;
    msg_t         target;
    msg_t         msg;

    irq_line_sync #(.N(N)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .lines_async (irq_lines),
        .level       (level),
        .change      (change)
    );

    irq_reg_bank #(.N(N), .IMPL_MASK(IMPL_MASK), .DATA_FIELD_W(DATA_FIELD_W)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .sel            (host_sel),
        .rd             (host_rd),
        .wr             (host_wr),
        .wdata          (host_wdata),
        .rdata          (host_rdata),
        .level          (level),
        .change         (change),
        .enabled_change (enabled_change),
        .enable_q       (enable_q),
        .pend_q         (pend_q),
        .req_q          (req_q),
        .target         (target)
    );

    irq_sender u_send (
        .clk    (clk),
        .rst    (rst),
        .fire   (|enabled_change),
        .target (target),
        .valid  (msg_valid),
        .ready  (msg_ready),
        .msg    (msg)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int           N         = 11,
    parameter logic [N-1:0] IMPL_MASK = 11'h5FF
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] change,
    input logic [N-1:0] enable_q,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] req_q,
    input logic         msg_valid,
    input logic         msg_ready,
    input logic [31:0]  msg_addr,
    input logic [31:0]  msg_data
);
    // R3
    pend_follows_change_chk: assert property (@(posedge clk) disable iff (rst)
        (|(change & enable_q)) |=> ((pend_q & $past(change & enable_q)) == $past(change & enable_q)));

    // R4
    masked_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(enable_q)) == '0));

    // R6
    unimpl_req_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_q & ~IMPL_MASK) == '0));

    // R7
    change_raises_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (|(change & enable_q)) |=> msg_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind irq_aggregator irq_agg_checker #(.N(N), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .change    (change),
    .enable_q  (enable_q),
    .pend_q    (pend_q),
    .req_q     (req_q),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int N = 11;
    localparam int NV = 6;
    // {enable, lines, expected pending, expected request}
    localparam logic [43:0] VEC [NV] = '{
        {11'h7FF, 11'h001, 11'h001, 11'h001},
        {11'h7FF, 11'h000, 11'h001, 11'h001},
        {11'h00F, 11'h0F0, 11'h000, 11'h000},
        {11'h0F0, 11'h0F0, 11'h000, 11'h000},
        {11'h7FF, 11'h600, 11'h6F0, 11'h4F0},
        {11'h200, 11'h000, 11'h200, 11'h000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_lines = '0;
    logic [2:0]  host_sel = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int n_cmp = 0;
    int n_bad = 0;
    int wcount = 0;
    int cyc = 0;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (!rst && msg_valid && msg_ready) wcount++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int w0;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 valid", {31'b0, msg_valid}, 32'h0);
        rd_reg(3'd0, r); check("R1 enable", r, 32'h0);
        rd_reg(3'd1, r); check("R1 pend", r, 32'h0);
        rd_reg(3'd3, r); check("R1 req", r, 32'h0);

        // target word: data field 0x34, address 0xABCD1200
        wr_reg(3'd4, 32'hABCD_1234);

        for (int v = 0; v < NV; v++) begin
            wr_reg(3'd0, {21'b0, VEC[v][43:33]});
            w0 = wcount;
            @(negedge clk);
            irq_lines = VEC[v][32:22];
            idle(6);
            // R2 live level
            rd_reg(3'd2, r); check("R2 level", r, {21'b0, VEC[v][32:22]});
            // R3 / R4 pending
            rd_reg(3'd1, r); check("R3/R4 pend", r, {21'b0, VEC[v][21:11]});
            // R5 level untouched by pending read
            rd_reg(3'd2, r); check("R5 level after pend read", r, {21'b0, VEC[v][32:22]});
            // R6 request
            rd_reg(3'd3, r); check("R6 req", r, {21'b0, VEC[v][10:0]});
            rd_reg(3'd1, r); check("R5 pend cleared", r, 32'h0);
            rd_reg(3'd3, r); check("R6 req cleared", r, 32'h0);
            // R7 one write per simultaneous change set
            check("R7 write count", 32'(wcount - w0), (VEC[v][21:11] != 0) ? 32'd1 : 32'd0);
        end

        // R5 request survives a pending read
        wr_reg(3'd0, 32'h004);
        @(negedge clk); irq_lines = 11'h004;
        idle(6);
        rd_reg(3'd1, r); check("R5 pend", r, 32'h004);
        rd_reg(3'd3, r); check("R5 req kept", r, 32'h004);

        // R7/R8/R9 stalled write
        wr_reg(3'd0, 32'h001);
        msg_ready = 1'b0;
        w0 = wcount;
        @(negedge clk); irq_lines = 11'h005;
        idle(4);
        check("R7 valid", {31'b0, msg_valid}, 32'h1);
        check("R7 addr", msg_addr, 32'hABCD_1200);
        check("R7 data", msg_data, 32'h0000_0034);
        irq_lines = 11'h004;
        wr_reg(3'd4, 32'h1111_2222);
        idle(6);
        check("R8 valid held", {31'b0, msg_valid}, 32'h1);
        check("R8 addr held", msg_addr, 32'hABCD_1200);
        msg_ready = 1'b1;
        idle(6);
        check("R9 write count", 32'(wcount - w0), 32'd2);
        check("R9 valid low", {31'b0, msg_valid}, 32'h0);

        // R4 enabling an asserted line raises nothing
        w0 = wcount;
        wr_reg(3'd0, 32'h7FF);
        idle(6);
        rd_reg(3'd1, r); check("R4 pend", r, 32'h001);
        rd_reg(3'd1, r);
        check("R4 no write", 32'(wcount - w0), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule